// File: doc/BRIEF.md
# NAND Data Port Width Adapter

This block connects a 32-bit register-style read port to an external NAND flash I/O bus that can be 8 or 16 bits wide. A requester pulses `start` with an access size (byte, half-word or word), the bus width and the byte order. The block then runs one to four flash read cycles in a row. Each cycle pulls the active-low read strobe low for a programmable number of clocks. After each cycle it waits out a programmable recovery gap before the next one.

Each sampled I/O value is written into its lane of the 32-bit result. The lane depends on the bus width, the access size and the byte order. Lanes that carry no data read as zero. When the last transfer has been captured, a one-cycle `done` pulse marks the result as valid. A combination the block cannot serve raises a one-cycle `err` pulse instead, and no flash cycle is run.

Top module: `nand_width_adapter`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low, `nand_re_n` is high and `rdata` is zero.
- R2: An accepted `start` (seen while `busy` is low) latches the size, width, byte order, strobe length and gap length, and raises `busy` on the next cycle. `busy` stays high until the cycle in which `done` rises. A `start` seen while `busy` is high is ignored: it changes neither the transfer count, the timing nor the result, and it raises no `err`.
- R3: For each transfer, `nand_re_n` is low for max(1, `strobe_len`) consecutive cycles. Between two transfers of one access it is high for max(1, `gap_len`) cycles. `nand_io` is sampled in the last low cycle.
- R4: With a 16-bit bus (`wide_bus`=1), little-endian order (`big_endian`=0) and a word access (`acc_size`=2), two transfers are run. The first fills `rdata[15:0]` and the second fills `rdata[31:16]`.
- R5: With a 16-bit bus, big-endian order (`big_endian`=1) and a word access, the first transfer fills `rdata[31:16]`, with its I/O[15:8] in bits 31:24. The second transfer fills `rdata[15:0]`.
- R6: With a 16-bit bus and a half-word access (`acc_size`=1), one transfer fills `rdata[15:0]` in either byte order, and `rdata[31:16]` is zero.
- R7: With an 8-bit bus (`wide_bus`=0) and a word access, four transfers are run using I/O[7:0]. In little-endian order they fill bytes 0, 1, 2, 3 in turn. In big-endian order they fill bytes 3, 2, 1, 0 in turn.
- R8: With an 8-bit bus and a half-word access, two transfers are run. In little-endian order the first goes to bits 7:0 and the second to bits 15:8. In big-endian order the first goes to bits 15:8 and the second to bits 7:0. `rdata[31:16]` is zero.
- R9: With an 8-bit bus and a byte access (`acc_size`=0), one transfer fills `rdata[7:0]` in either byte order, and `rdata[31:8]` is zero.
- R10: The block flags two cases as errors: a byte access on a 16-bit bus, and the reserved size code 3. For either, an accepted `start` gives a one-cycle `err` pulse on the next cycle. No strobe is driven, `busy` stays low and no `done` follows.
- R11: `done` is a one-cycle pulse in the cycle after the last strobe cycle, and `rdata` is valid in that cycle. `rdata` then holds its value until the next accepted `start`. `done` and `err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse |
| acc_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| wide_bus | input | 1 | 1 selects the 16-bit flash bus, 0 the 8-bit bus |
| big_endian | input | 1 | 1 selects big-endian lane order |
| strobe_len | input | STRB_W | Strobe low cycles (0 counts as 1) |
| gap_len | input | GAP_W | Recovery cycles between strobes (0 counts as 1) |
| busy | output | 1 | A read sequence is running |
| done | output | 1 | One-cycle pulse, result valid |
| err | output | 1 | One-cycle pulse, unsupported request |
| rdata | output | 32 | Assembled result |
| nand_re_n | output | 1 | Active-low flash read strobe |
| nand_io | input | 16 | Flash I/O bus |

## Verification
The bench builds the block with its default 4-bit strobe and gap counters, so lengths from 0 to 15 can be set. The bench drives strobe and gap values of 0, 1, 3 and 15. These cover the clamp from zero to one, single-cycle strobes where sampling and release fall on the same edge, and long strobes that hold the sequencer in one state for many cycles. A flash model in the bench returns a different value on every strobe, so a transfer placed in the wrong lane or captured in the wrong order changes the result.

// File: rtl/nwa_pkg.sv
// Shared types and sizing for the NAND width adapter.
// Assumes a 32-bit requester port and a flash bus of at most 16 bits.
package nwa_pkg;
    parameter int DATA_W = 32;
    parameter int IO_W   = 16;
    localparam int LANES = DATA_W / 8;
    localparam int IDX_W = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } nwa_size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_GAP    = 2'd2
    } nwa_state_e;
endpackage

// File: rtl/nwa_decode.sv
// Request decoder: works out whether a size/width pair is legal and the
// index of the last transfer (transfers minus one).
// Assumes: purely combinational, so inputs are used only at the accept cycle.
module nwa_decode
    import nwa_pkg::*;
(
    input  logic [1:0]       size,
    input  logic             wide,
    output logic             legal,
    output logic [IDX_W-1:0] last_idx
);
    // Legality and transfer count from access size and bus width.
    always_comb begin
        legal    = 1'b1;
        last_idx = '0;
        unique case (nwa_size_e'(size))
            SZ_BYTE: begin
                legal    = !wide;
                last_idx = '0;
            end
            SZ_HALF: last_idx = wide ? IDX_W'(0) : IDX_W'(1);
            SZ_WORD: last_idx = wide ? IDX_W'(1) : IDX_W'(3);
            default: legal    = 1'b0;
        endcase
    end
endmodule

// File: rtl/nwa_sequencer.sv
// Flash read-cycle sequencer: runs last_idx+1 strobes, each low for
// max(1,strobe_len) cycles, with max(1,gap_len) recovery cycles between.
// Assumes: go is only asserted while busy is low.
module nwa_sequencer
    import nwa_pkg::*;
#(
    parameter int STRB_W = 4,
    parameter int GAP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic [STRB_W-1:0] strobe_len,
    input  logic [GAP_W-1:0]  gap_len,
    output logic              re_n,
    output logic              busy,
    output logic              sample,
    output logic              final_xfer,
    output logic [IDX_W-1:0]  xfer_idx
);
    nwa_state_e        state_q;
    logic [STRB_W-1:0] scnt_q, slim_q;
    logic [GAP_W-1:0]  gcnt_q, glim_q;
    logic [IDX_W-1:0]  idx_q, last_q;

    // Strobe and gap limits, with zero clamped to one cycle.
    logic [STRB_W-1:0] slim_in;
    logic [GAP_W-1:0]  glim_in;
    always_comb begin
        slim_in = (strobe_len == '0) ? '0 : strobe_len - 1'b1;
        glim_in = (gap_len == '0) ? '0 : gap_len - 1'b1;
    end

    // Sampling happens in the last low cycle of each strobe.
    always_comb begin
        sample     = (state_q == ST_STROBE) && (scnt_q == slim_q);
        final_xfer = sample && (idx_q == last_q);
        re_n       = (state_q != ST_STROBE);
        busy       = (state_q != ST_IDLE);
        xfer_idx   = idx_q;
    end

    // Main state machine and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            scnt_q  <= '0;
            gcnt_q  <= '0;
            slim_q  <= '0;
            glim_q  <= '0;
            idx_q   <= '0;
            last_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (go) begin
                    state_q <= ST_STROBE;
                    slim_q  <= slim_in;
                    glim_q  <= glim_in;
                    last_q  <= last_idx;
                    idx_q   <= '0;
                    scnt_q  <= '0;
                end
                ST_STROBE: begin
                    if (scnt_q == slim_q) begin
                        gcnt_q  <= '0;
                        state_q <= (idx_q == last_q) ? ST_IDLE : ST_GAP;
                    end else begin
                        scnt_q <= scnt_q + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (gcnt_q == glim_q) begin
                        state_q <= ST_STROBE;
                        scnt_q  <= '0;
                        idx_q   <= idx_q + 1'b1;
                    end else begin
                        gcnt_q <= gcnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Checker counters: length of the current low and high runs of re_n.
    logic [STRB_W:0] low_run_q;
    logic [GAP_W:0]  high_run_q;
    logic            seen_low_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run_q  <= '0;
            high_run_q <= '0;
            seen_low_q <= 1'b0;
        end else begin
            low_run_q  <= re_n ? '0 : low_run_q + 1'b1;
            high_run_q <= re_n ? high_run_q + 1'b1 : '0;
            if (!re_n) seen_low_q <= 1'b1;
            else if (!busy) seen_low_q <= 1'b0;
        end
    end

    // R3: each strobe stays low for exactly the clamped strobe length.
    assert_strobe_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (re_n && low_run_q != '0) |-> (low_run_q == {1'b0, slim_q} + 1'b1));

    // R3: the recovery gap inside one access has the clamped gap length.
    assert_gap_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!re_n && seen_low_q && high_run_q != '0) |-> (high_run_q == {1'b0, glim_q} + 1'b1));
endmodule

// File: rtl/nwa_packer.sv
// Lane packer: writes each sampled I/O value into the byte lanes picked by
// bus width, byte order and transfer index; clears all lanes on a new request.
// Assumes: config inputs are held stable for the whole access.
module nwa_packer
    import nwa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              wide,
    input  logic              big,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic [IDX_W-1:0]  xfer_idx,
    input  logic [IO_W-1:0]   io,
    output logic [DATA_W-1:0] data
);
    // Slot of the current transfer: reversed order for big-endian.
    logic [IDX_W-1:0] slot;
    always_comb slot = big ? (last_idx - xfer_idx) : xfer_idx;

    logic [7:0] lane_q [LANES];

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        localparam logic [IDX_W-1:0] SLOT_N = IDX_W'(b);
        localparam logic [IDX_W-1:0] SLOT_W = IDX_W'(b / 2);
        localparam int               HALF   = b % 2;

        logic       hit;
        logic [7:0] src;
        // Lane select and source byte for this lane.
        always_comb begin
            hit = wide ? (slot == SLOT_W) : (slot == SLOT_N);
            src = wide ? io[8*HALF +: 8] : io[7:0];
        end

        // Lane register: cleared on request, loaded on a matching sample.
        always_ff @(posedge clk) begin
            if (!rst_n)             lane_q[b] <= '0;
            else if (clear)         lane_q[b] <= '0;
            else if (sample && hit) lane_q[b] <= src;
        end

        always_comb data[8*b +: 8] = lane_q[b];
    end
endmodule

// File: rtl/nand_width_adapter.sv
// NAND data port width adapter: turns one byte/half/word read request into
// 1..4 flash read cycles and assembles the result in the chosen byte order.
// Assumes: nand_io is stable during the last low cycle of each strobe.
module nand_width_adapter
    import nwa_pkg::*;
#(
    parameter int STRB_W = 4,
    parameter int GAP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        acc_size,
    input  logic              wide_bus,
    input  logic              big_endian,
    input  logic [STRB_W-1:0] strobe_len,
    input  logic [GAP_W-1:0]  gap_len,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              nand_re_n,
    input  logic [IO_W-1:0]   nand_io
);
    logic             legal, accept, reject;
    logic [IDX_W-1:0] last_idx, last_q, xfer_idx;
    logic             sample, final_xfer;
    logic             wide_q, big_q, done_q, err_q;

    nwa_decode u_decode (
        .size     (acc_size),
        .wide     (wide_bus),
        .legal    (legal),
        .last_idx (last_idx)
    );

    // Requests are taken only while idle.
    always_comb begin
        accept = start && !busy && legal;
        reject = start && !busy && !legal;
    end

    // Latch access configuration at accept time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q <= 1'b0;
            big_q  <= 1'b0;
            last_q <= '0;
        end else if (accept) begin
            wide_q <= wide_bus;
            big_q  <= big_endian;
            last_q <= last_idx;
        end
    end

    nwa_sequencer #(.STRB_W(STRB_W), .GAP_W(GAP_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (accept),
        .last_idx   (last_idx),
        .strobe_len (strobe_len),
        .gap_len    (gap_len),
        .re_n       (nand_re_n),
        .busy       (busy),
        .sample     (sample),
        .final_xfer (final_xfer),
        .xfer_idx   (xfer_idx)
    );

    nwa_packer u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .sample   (sample),
        .wide     (wide_q),
        .big      (big_q),
        .last_idx (last_q),
        .xfer_idx (xfer_idx),
        .io       (nand_io),
        .data     (rdata)
    );

    // One-cycle done and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= final_xfer;
            err_q  <= reject;
        end
    end
    always_comb begin
        done = done_q;
        err  = err_q;
    end

    // Checker counter: transfers sampled since the last accept.
    logic [IDX_W:0] xcnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n)      xcnt_q <= '0;
        else if (accept) xcnt_q <= '0;
        else if (sample) xcnt_q <= xcnt_q + 1'b1;
    end

    // R10: a rejected request pulses err and starts no flash cycle.
    assert_reject_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> (err && !busy && nand_re_n));

    // R10, R11: done and err never overlap.
    assert_done_err_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err}));

    // R2: busy only rises after a start request.
    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R11: done arrives with the sequencer back at idle.
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: the number of sampled transfers matches the decoded count.
    assert_xfer_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (xcnt_q == {1'b0, last_q} + 1'b1));
endmodule

// File: tb/nand_width_adapter_tb.sv
// Scoreboard bench: driver tasks push expected results, a monitor compares
// them on done and also checks strobe and gap widths at the pins.
module nand_width_adapter_tb;
    localparam int STRB_W = 4;
    localparam int GAP_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        acc_size = '0;
    logic              wide_bus = 1'b0;
    logic              big_endian = 1'b0;
    logic [STRB_W-1:0] strobe_len = '0;
    logic [GAP_W-1:0]  gap_len = '0;
    logic              busy, done, err, nand_re_n;
    logic [31:0]       rdata;
    logic [15:0]       nand_io = '0;

    always #5 clk = ~clk;

    nand_width_adapter #(.STRB_W(STRB_W), .GAP_W(GAP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .acc_size(acc_size),
        .wide_bus(wide_bus), .big_endian(big_endian), .strobe_len(strobe_len),
        .gap_len(gap_len), .busy(busy), .done(done), .err(err),
        .rdata(rdata), .nand_re_n(nand_re_n), .nand_io(nand_io)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Flash model: a fresh value on every strobe.
    logic [15:0] cur_seed = '0;
    int          xfer_k = 0;
    always @(negedge nand_re_n) nand_io = cur_seed + 16'(xfer_k) * 16'h1111;
    always @(posedge nand_re_n) xfer_k = xfer_k + 1;

    function automatic logic [15:0] fv(input logic [15:0] seed, input int k);
        return seed + 16'(k) * 16'h1111;
    endfunction

    // Scoreboard queues.
    logic [31:0] q_data [$];
    int          q_n    [$];
    string       q_req  [$];
    int          exp_slen = 1, exp_gap = 1;

    // Monitor: strobe/gap widths and results on done.
    int low_run = 0, high_run = 0, seen = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!nand_re_n) begin
                if (low_run == 0 && seen > 0)
                    chk(high_run == exp_gap, "R3 gap", 32'(high_run), 32'(exp_gap));
                low_run++;
                high_run = 0;
            end else begin
                if (low_run > 0) begin
                    chk(low_run == exp_slen, "R3 strobe", 32'(low_run), 32'(exp_slen));
                    seen++;
                end
                low_run = 0;
                high_run++;
            end
            if (done) begin
                if (q_data.size() == 0) begin
                    chk(1'b0, "R11 unexpected done", 32'(1), 32'(0));
                end else begin
                    logic [31:0] ed;
                    int en;
                    string rq;
                    ed = q_data.pop_front();
                    en = q_n.pop_front();
                    rq = q_req.pop_front();
                    chk(rdata === ed, rq, rdata, ed);
                    chk(seen == en, {rq, " count"}, 32'(seen), 32'(en));
                end
                seen = 0;
            end
        end
    end

    // Expected result from the placement rules.
    function automatic logic [31:0] expect_data(input bit w, input bit be, input logic [1:0] sz, input logic [15:0] s);
        logic [15:0] v0, v1;
        logic [7:0]  b0, b1, b2, b3;
        v0 = fv(s, 0); v1 = fv(s, 1);
        b0 = v0[7:0]; b1 = v1[7:0]; b2 = fv(s, 2) & 16'hFF; b3 = fv(s, 3) & 16'hFF;
        if (w) begin
            if (sz == 2'd2) return be ? {v0, v1} : {v1, v0};
            return {16'h0, v0};
        end
        case (sz)
            2'd2:    return be ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
            2'd1:    return be ? {16'h0, b0, b1} : {16'h0, b1, b0};
            default: return {24'h0, b0};
        endcase
    endfunction

    function automatic int expect_n(input bit w, input logic [1:0] sz);
        if (w) return (sz == 2'd2) ? 2 : 1;
        return (sz == 2'd2) ? 4 : (sz == 2'd1) ? 2 : 1;
    endfunction

    // Driver: push expectation, pulse start, wait for completion.
    task automatic run(input bit w, input bit be, input logic [1:0] sz,
                       input int sl, input int gl, input logic [15:0] seed,
                       input string req, input bit poke_busy);
        logic [31:0] ed;
        ed = expect_data(w, be, sz, seed);
        q_data.push_back(ed);
        q_n.push_back(expect_n(w, sz));
        q_req.push_back(req);
        exp_slen = (sl == 0) ? 1 : sl;
        exp_gap  = (gl == 0) ? 1 : gl;
        cur_seed = seed;
        xfer_k   = 0;
        @(negedge clk);
        wide_bus = w; big_endian = be; acc_size = sz;
        strobe_len = STRB_W'(sl); gap_len = GAP_W'(gl);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R2 busy after start", 32'(busy), 32'(1));
        if (poke_busy) begin
            // R2: starts while busy, one illegal and one legal, must be ignored.
            @(negedge clk);
            wide_bus = 1'b1; acc_size = 2'd0; start = 1'b1;
            @(negedge clk);
            chk(err === 1'b0, "R2 no err while busy", 32'(err), 32'(0));
            wide_bus = 1'b0; acc_size = 2'd2; big_endian = ~be;
            strobe_len = 4'd2; gap_len = 4'd3;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        chk(done === 1'b1, "R11 done with idle", 32'(done), 32'(1));
        @(negedge clk);
        chk(done === 1'b0, "R11 done one cycle", 32'(done), 32'(0));
        chk(rdata === ed, "R11 rdata held", rdata, ed);
    endtask

    task automatic run_err(input bit w, input logic [1:0] sz, input string req);
        int strobes;
        strobes = 0;
        @(negedge clk);
        wide_bus = w; acc_size = sz; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err === 1'b1, req, 32'(err), 32'(1));
        chk(busy === 1'b0, {req, " busy"}, 32'(busy), 32'(0));
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!nand_re_n || done) strobes++;
            if (i == 0) chk(err === 1'b0, {req, " pulse"}, 32'(err), 32'(0));
        end
        chk(strobes == 0, {req, " no strobe"}, 32'(strobes), 32'(0));
    endtask

    // Watchdog.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1 flags", {29'h0, busy, done, err}, 32'h0);
        chk(nand_re_n === 1'b1, "R1 strobe idle", 32'(nand_re_n), 32'(1));
        chk(rdata === 32'h0, "R1 rdata", rdata, 32'h0);

        run(1'b1, 1'b0, 2'd2, 1, 1, 16'hA1B2, "R4 16b word LE", 1'b0);
        run(1'b1, 1'b1, 2'd2, 3, 2, 16'hC3D4, "R5 16b word BE", 1'b0);
        run(1'b1, 1'b0, 2'd1, 0, 0, 16'h5E6F, "R6 16b half LE", 1'b0);
        run(1'b1, 1'b1, 2'd1, 2, 1, 16'h7788, "R6 16b half BE", 1'b0);
        run(1'b0, 1'b0, 2'd2, 1, 0, 16'h0102, "R7 8b word LE", 1'b0);
        run(1'b0, 1'b1, 2'd2, 15, 15, 16'h3344, "R7 8b word BE", 1'b0);
        run(1'b0, 1'b0, 2'd1, 3, 3, 16'h90AB, "R8 8b half LE", 1'b0);
        run(1'b0, 1'b1, 2'd1, 1, 2, 16'hCDEF, "R8 8b half BE", 1'b0);
        run(1'b0, 1'b0, 2'd0, 2, 1, 16'h1E2D, "R9 8b byte LE", 1'b0);
        run(1'b0, 1'b1, 2'd0, 0, 1, 16'h4B5A, "R9 8b byte BE", 1'b0);
        run(1'b0, 1'b0, 2'd2, 1, 1, 16'h6677, "R2 ignore start", 1'b1);
        run_err(1'b1, 2'd0, "R10 byte on 16b");
        run_err(1'b0, 2'd3, "R10 reserved size");
        run(1'b1, 1'b1, 2'd2, 1, 1, 16'h2468, "R5 after error", 1'b0);

        repeat (4) @(negedge clk);
        chk(q_data.size() == 0, "R11 all results seen", 32'(q_data.size()), 32'(0));
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule